// File: doc/BRIEF.md
# Flash Sector Erase and Byte Program Sequencer

This block drives a parallel flash that sits behind a banked 16 KB program window. It takes one command at a time, either a 4 KB sector erase or a single byte program, and turns it into the bus traffic the flash needs. The flash sees only the window, so before every data write the sequencer writes a bank number into the bank register at `$C000`. That number sets the upper flash address lines. Once the final write is out, the sequencer reads the target location over and over until the flash reports completion.

A host pulses `start` with the operation, bank, window address and data byte. It then waits for a one-clock `done` pulse or a one-clock `err` pulse. The command inputs and the completion pulses are plain control pins. The bus side is a simple master: every access lasts exactly one clock with `bus_strobe` high, and the slave must answer a read within that same cycle, so there is no back-pressure on the bus. A poll limit is captured with the command and bounds how many reads are made before the command gives up.

Top module: `flash_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `bus_strobe` are 0, `bus_rnw` is 1, and `bus_addr` and `bus_wdata` are 0.
- R2: A start is rejected when the bank is 32 or more, when the address lies outside `$8000`-`$BFFF`, or when an erase address has any of its low 12 bits set. A rejected start pulses `err` in the next cycle, leaves `busy` low and makes no bus access.
- R3: With `op`=1 (program), the block makes 8 writes. As (address, data) pairs they are: (`$C000`,`$01`), (`$9555`,`$AA`), (`$C000`,`$00`), (`$AAAA`,`$55`), (`$C000`,`$01`), (`$9555`,`$A0`), (`$C000`,bank), (target,data).
- R4: With `op`=0 (erase), the block makes 12 writes: the four-write unlock pattern from R3, then (`$C000`,`$01`), (`$9555`,`$80`), the unlock pattern again, then (`$C000`,bank), (target,`$30`).
- R5: Each write is one clock with `bus_strobe`=1 and `bus_rnw`=0. Each write to an address other than `$C000` comes straight after a write to `$C000`. The first access after an accepted start is a write to `$C000`.
- R6: After the last write, the block makes one-clock reads of the target address with `bus_rnw`=1. It pulses `done` once two reads in a row both return the expected value: `$FF` for an erase, the data byte for a program. A mismatching read restarts the pair count.
- R7: If the number of reads reaches `poll_limit` (captured at start) without success, `err` pulses instead of `done`. A limit of 0 or 1 therefore fails after the first read.
- R8: `busy` is 1 from the cycle after an accepted start through the last bus access, and falls in the cycle where `done` or `err` pulses. `done` and `err` last one clock and are never high together. `start` is ignored while `busy` is 1.
- R9: When no access is in progress, `bus_strobe`=0 and `bus_rnw`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, sampled while idle |
| op | input | 1 | 1 = byte program, 0 = sector erase |
| bank | input | 8 | Target flash bank (valid 0-31) |
| addr | input | 16 | Target address in the program window |
| data | input | 8 | Byte to program |
| poll_limit | input | 16 | Maximum number of completion reads |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-clock success pulse |
| err | output | 1 | One-clock reject or timeout pulse |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 8 | Bus write data |
| bus_rnw | output | 1 | 1 = read, 0 = write |
| bus_strobe | output | 1 | Access cycle strobe |
| bus_rdata | input | 8 | Bus read data, sampled at the end of a read cycle |

## Verification
The assertions check on every cycle that a rejected start draws an error with no bus access, that an accepted start opens with a bank-register write, that every data write follows a bank-register write, and that completion pulses are single, exclusive and only follow a read. The exact order of the 8 and 12 write patterns, the two-in-a-row completion rule under glitching read data, the poll-limit cut-off and the count of busy cycles depend on scenario data. Only the bench's scenarios can show them, by comparing each logged access with a sequence it computes itself.

// File: rtl/flseq_pkg.sv
package flseq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_POLL} st_t;
  typedef enum logic {OP_ERASE = 1'b0, OP_PROG = 1'b1} op_t;
  typedef enum logic [1:0] {K_UNL1, K_UNL2, K_CMD, K_TGT} kind_t;

  localparam logic [15:0] BANK_REG_ADDR = 16'hC000;
  localparam logic [15:0] UNL_ADDR1     = 16'h9555;
  localparam logic [15:0] UNL_ADDR2     = 16'hAAAA;
  localparam logic [7:0]  UNL_DATA1     = 8'hAA;
  localparam logic [7:0]  UNL_DATA2     = 8'h55;
  localparam logic [7:0]  CMD_PROG      = 8'hA0;
  localparam logic [7:0]  CMD_ERASE     = 8'h80;
  localparam logic [7:0]  CMD_SECTOR    = 8'h30;
  localparam logic [7:0]  BANK_ONE      = 8'h01;
  localparam logic [7:0]  BANK_ZERO     = 8'h00;

  localparam int PROG_WRITES  = 8;
  localparam int ERASE_WRITES = 12;
  localparam int IDX_W        = $clog2(ERASE_WRITES);
endpackage

// File: rtl/flseq_cmd_check.sv
module flseq_cmd_check
  import flseq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int NUM_BANKS   = 32,
  parameter int SECTOR_BITS = 12
) (
  input  op_t               op,
  input  logic [DATA_W-1:0] bank,
  input  logic [ADDR_W-1:0] addr,
  output logic              ok
);
  localparam logic [DATA_W:0]   BANK_LIM  = NUM_BANKS[DATA_W:0];
  localparam logic [ADDR_W-1:0] SECT_MASK = ADDR_W'((1 << SECTOR_BITS) - 1);

  logic bank_ok, win_ok, sect_ok;

  always_comb begin
    bank_ok = {1'b0, bank} < BANK_LIM;
    win_ok  = (addr >> (ADDR_W - 2)) == ADDR_W'(2);
    sect_ok = (addr & SECT_MASK) == '0;
    ok      = bank_ok && win_ok && (op == OP_PROG || sect_ok);
  end
endmodule

// File: rtl/flseq_step_gen.sv
module flseq_step_gen
  import flseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  op_t               op,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] bank,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              last
);
  logic [IDX_W-2:0]  pair;
  kind_t             kind;
  logic [DATA_W-1:0] bnk, dd;
  logic [ADDR_W-1:0] da;

  always_comb begin
    pair = idx[IDX_W-1:1];
    if (op == OP_PROG) begin
      last = idx == IDX_W'(PROG_WRITES - 1);
      case (pair)
        0:       kind = K_UNL1;
        1:       kind = K_UNL2;
        2:       kind = K_CMD;
        default: kind = K_TGT;
      endcase
    end else begin
      last = idx == IDX_W'(ERASE_WRITES - 1);
      case (pair)
        0, 3:    kind = K_UNL1;
        1, 4:    kind = K_UNL2;
        2:       kind = K_CMD;
        default: kind = K_TGT;
      endcase
    end
    case (kind)
      K_UNL1: begin bnk = DATA_W'(BANK_ONE);  da = ADDR_W'(UNL_ADDR1); dd = DATA_W'(UNL_DATA1); end
      K_UNL2: begin bnk = DATA_W'(BANK_ZERO); da = ADDR_W'(UNL_ADDR2); dd = DATA_W'(UNL_DATA2); end
      K_CMD:  begin
        bnk = DATA_W'(BANK_ONE);
        da  = ADDR_W'(UNL_ADDR1);
        dd  = (op == OP_PROG) ? DATA_W'(CMD_PROG) : DATA_W'(CMD_ERASE);
      end
      default: begin
        bnk = bank;
        da  = addr;
        dd  = (op == OP_PROG) ? data : DATA_W'(CMD_SECTOR);
      end
    endcase
    wr_addr = idx[0] ? da : ADDR_W'(BANK_REG_ADDR);
    wr_data = idx[0] ? dd : bnk;
  end
endmodule

// File: rtl/flseq_poll.sv
module flseq_poll #(
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               sample,
  input  logic               match,
  input  logic [LIMIT_W-1:0] limit,
  output logic               hit2,
  output logic               expire
);
  logic               prev_ok;
  logic [LIMIT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      prev_ok <= 1'b0;
      cnt     <= '0;
    end else if (sample) begin
      prev_ok <= match;
      cnt     <= cnt + 1'b1;
    end
  end

  assign hit2   = sample && match && prev_ok;
  assign expire = sample && (({1'b0, cnt} + (LIMIT_W+1)'(1)) >= {1'b0, limit});
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flseq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int NUM_BANKS   = 32,
  parameter int SECTOR_BITS = 12,
  parameter int LIMIT_W     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               op,
  input  logic [DATA_W-1:0]  bank,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  data,
  input  logic [LIMIT_W-1:0] poll_limit,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_wdata,
  output logic               bus_rnw,
  output logic               bus_strobe,
  input  logic [DATA_W-1:0]  bus_rdata
);
  st_t                state;
  logic [IDX_W-1:0]   idx;
  op_t                q_op;
  logic [DATA_W-1:0]  q_bank, q_data;
  logic [ADDR_W-1:0]  q_addr;
  logic [LIMIT_W-1:0] q_limit;
  logic               cmd_ok, last, hit2, expire, match;
  logic [ADDR_W-1:0]  wr_addr;
  logic [DATA_W-1:0]  wr_data;

  flseq_cmd_check #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS),
                    .SECTOR_BITS(SECTOR_BITS)) u_check (
    .op(op_t'(op)), .bank(bank), .addr(addr), .ok(cmd_ok));

  flseq_step_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_steps (
    .op(q_op), .idx(idx), .bank(q_bank), .addr(q_addr), .data(q_data),
    .wr_addr(wr_addr), .wr_data(wr_data), .last(last));

  assign match = bus_rdata == ((q_op == OP_PROG) ? q_data : '1);

  flseq_poll #(.LIMIT_W(LIMIT_W)) u_poll (
    .clk(clk), .rst_n(rst_n), .clear(state == ST_IDLE), .sample(state == ST_POLL),
    .match(match), .limit(q_limit), .hit2(hit2), .expire(expire));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      idx     <= '0;
      q_op    <= OP_ERASE;
      q_bank  <= '0;
      q_addr  <= '0;
      q_data  <= '0;
      q_limit <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          if (cmd_ok) begin
            q_op    <= op_t'(op);
            q_bank  <= bank;
            q_addr  <= addr;
            q_data  <= data;
            q_limit <= poll_limit;
            idx     <= '0;
            state   <= ST_WRITE;
          end else begin
            err <= 1'b1;
          end
        end
        ST_WRITE: begin
          if (last) state <= ST_POLL;
          else      idx   <= idx + 1'b1;
        end
        ST_POLL: begin
          if (hit2) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else if (expire) begin
            err   <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy       = state != ST_IDLE;
    bus_strobe = state != ST_IDLE;
    bus_rnw    = state != ST_WRITE;
    bus_addr   = (state == ST_WRITE) ? wr_addr : (state == ST_POLL) ? q_addr : '0;
    bus_wdata  = (state == ST_WRITE) ? wr_data : '0;
  end
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int NUM_BANKS   = 32,
  parameter int SECTOR_BITS = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              op,
  input logic [DATA_W-1:0] bank,
  input logic [ADDR_W-1:0] addr,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rnw,
  input logic              bus_strobe
);
  localparam logic [ADDR_W-1:0] REG_A = ADDR_W'(16'hC000);
  localparam logic [ADDR_W-1:0] LOWM  = ADDR_W'((1 << SECTOR_BITS) - 1);
  logic bad_cmd;
  assign bad_cmd = ({24'd0, bank} >= 32'(NUM_BANKS)) || ((addr >> (ADDR_W - 2)) != ADDR_W'(2))
                   || (!op && ((addr & LOWM) != '0));

  AST_REJECT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && bad_cmd) |=> (err && !busy && !bus_strobe)); // R2
  AST_FIRST_BANK_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !bad_cmd) |=> (busy && bus_strobe && !bus_rnw && bus_addr == REG_A)); // R5
  AST_DATA_AFTER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && !bus_rnw && bus_addr != REG_A) |-> $past(bus_strobe && !bus_rnw && bus_addr == REG_A)); // R5
  AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bus_strobe && bus_rnw)); // R6
  AST_EXCL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err)); // R8
  AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_END_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !busy); // R8
  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_strobe |-> bus_rnw); // R9
endmodule

bind flash_seq flash_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS),
                               .SECTOR_BITS(SECTOR_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .bank(bank), .addr(addr),
  .busy(busy), .done(done), .err(err), .bus_addr(bus_addr), .bus_rnw(bus_rnw),
  .bus_strobe(bus_strobe));

// File: tb/sim_flash_seq.sv
module sim_flash_seq;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, op = 1'b0;
  logic [7:0] bank = '0, data = '0, bus_rdata, bus_wdata;
  logic [15:0] addr = '0, poll_limit = '0, bus_addr;
  logic busy, done, err, bus_rnw, bus_strobe;

  always #5 clk = ~clk;

  flash_seq u0 (.clk(clk), .rst_n(rst_n), .start(start), .op(op), .bank(bank), .addr(addr),
    .data(data), .poll_limit(poll_limit), .busy(busy), .done(done), .err(err),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rnw(bus_rnw), .bus_strobe(bus_strobe),
    .bus_rdata(bus_rdata));

  int checks = 0, errors = 0;
  // flash read model
  logic [7:0] cur_exp = 8'hFF;
  int rd_cnt = 0, r_ready = 0, r_glitch = -1;
  assign bus_rdata = (rd_cnt >= r_ready && rd_cnt != r_glitch) ? cur_exp : ~cur_exp;
  always @(posedge clk) if (bus_strobe && bus_rnw) rd_cnt <= rd_cnt + 1;

  // access log, sampled at negedge
  logic [15:0] la [0:127];
  logic [7:0]  ld [0:127];
  logic        lr [0:127];
  int n_acc = 0, busy_cnt = 0;
  always @(negedge clk) begin
    if (bus_strobe && n_acc < 128) begin
      la[n_acc] <= bus_addr; ld[n_acc] <= bus_wdata; lr[n_acc] <= bus_rnw;
      n_acc <= n_acc + 1;
    end
    if (busy) busy_cnt <= busy_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit cmd_valid(input bit o, input [7:0] b, input [15:0] a);
    return b < 8'd32 && a[15:14] == 2'b10 && (o || a[11:0] == 12'h000);
  endfunction

  function automatic void exp_wr(input bit o, input int k, input [7:0] b, input [15:0] a,
                                 input [7:0] d, output [15:0] ea, output [7:0] ed);
    int p = k / 2;
    int kind;
    logic [7:0] bk, dv;
    logic [15:0] av;
    if (o) kind = (p < 3) ? p : 3;
    else   kind = (p == 5) ? 3 : ((p >= 3) ? p - 3 : p);
    case (kind)
      0: begin bk = 8'h01; av = 16'h9555; dv = 8'hAA; end
      1: begin bk = 8'h00; av = 16'hAAAA; dv = 8'h55; end
      2: begin bk = 8'h01; av = 16'h9555; dv = o ? 8'hA0 : 8'h80; end
      default: begin bk = b; av = a; dv = o ? d : 8'h30; end
    endcase
    ea = (k % 2 == 0) ? 16'hC000 : av;
    ed = (k % 2 == 0) ? bk : dv;
  endfunction

  task automatic run_op(input bit o, input [7:0] b, input [15:0] a, input [7:0] d,
                        input int ready, input int glitch, input [15:0] lim, input bit poke);
    int nw = o ? 8 : 12;
    int nr = 0;
    bit exp_done = 0;
    int wait_cyc = 0;
    bit bad_wr = 0, bad_rd = 0;
    logic [15:0] ea;
    logic [7:0] ed;
    cur_exp = o ? d : 8'hFF; r_ready = ready; r_glitch = glitch;
    @(negedge clk);
    rd_cnt = 0; n_acc = 0; busy_cnt = 0;
    start = 1; op = o; bank = b; addr = a; data = d; poll_limit = lim;
    @(negedge clk);
    start = 0;
    if (!cmd_valid(o, b, a)) begin
      chk(err && !busy && !bus_strobe, "R2", "reject err/busy/strobe",
          {err, busy, bus_strobe}, 3'b100);
      @(negedge clk);
      chk(!err && n_acc == 0, "R2", "reject pulse/no access", {err, 8'(n_acc)}, 0);
      return;
    end
    if (poke) begin
      @(negedge clk);
      start = 1; bank = 8'hFF; addr = 16'h0001;
      @(negedge clk);
      start = 0;
    end
    while (!(done || err) && wait_cyc < 2000) begin
      @(negedge clk);
      wait_cyc++;
    end
    // expected outcome per R6/R7
    for (int j = 0; j < 1000; j++) begin
      bit gj = (j >= ready && j != glitch);
      bit gp = (j > 0 && (j - 1) >= ready && (j - 1) != glitch);
      if (gj && gp) begin exp_done = 1; nr = j + 1; break; end
      if (j + 1 >= int'(lim)) begin exp_done = 0; nr = j + 1; break; end
    end
    chk(done == exp_done && err == !exp_done, exp_done ? "R6" : "R7", "outcome done/err",
        {done, err}, {exp_done, !exp_done});
    chk(n_acc == nw + nr, exp_done ? "R6" : "R7", "access count", n_acc, nw + nr);
    for (int k = 0; k < nw; k++) begin
      exp_wr(o, k, b, a, d, ea, ed);
      if (la[k] != ea || ld[k] != ed || lr[k] != 1'b0) bad_wr = 1;
    end
    chk(!bad_wr, o ? "R3" : "R4", "write sequence (R5 bank before data)", bad_wr, 0);
    for (int k = nw; k < n_acc && k < 128; k++)
      if (la[k] != a || lr[k] != 1'b1) bad_rd = 1;
    chk(!bad_rd, "R6", "poll reads target", bad_rd, 0);
    chk(busy_cnt == nw + nr && !busy, "R8", "busy cycles", busy_cnt, nw + nr);
    @(negedge clk);
    chk(!done && !err, "R8", "single-cycle pulse", {done, err}, 0);
    chk(!bus_strobe && bus_rnw && bus_addr == 0, "R9", "idle bus",
        {bus_strobe, bus_rnw, bus_addr}, 17'h10000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !bus_strobe && bus_rnw && bus_addr == 0 && bus_wdata == 0,
        "R1", "reset state", {busy, done, err, bus_strobe, bus_rnw}, 5'b00001);
    rst_n = 1;
    // directed corners
    run_op(1, 8'h00, 16'h8000, 8'h5A, 0, -1, 16'd20, 0);   // R3 fastest done
    run_op(0, 8'h1F, 16'hB000, 8'h00, 3, 4, 16'd20, 0);    // R4 with glitch
    run_op(1, 8'h07, 16'hBFFF, 8'hFF, 0, 1, 16'd20, 0);    // R6 pair restarts
    run_op(1, 8'h02, 16'h9123, 8'h11, 0, -1, 16'd1, 0);    // R7 limit 1
    run_op(0, 8'h03, 16'h9000, 8'h00, 5, -1, 16'd3, 0);    // R7 timeout
    run_op(1, 8'h04, 16'hA000, 8'h3C, 2, -1, 16'd20, 1);   // R8 start ignored while busy
    run_op(1, 8'h20, 16'h8000, 8'h00, 0, -1, 16'd20, 0);   // R2 bank 32
    run_op(1, 8'h01, 16'h7FFF, 8'h00, 0, -1, 16'd20, 0);   // R2 below window
    run_op(1, 8'h01, 16'hC000, 8'h00, 0, -1, 16'd20, 0);   // R2 above window
    run_op(0, 8'h01, 16'h8001, 8'h00, 0, -1, 16'd20, 0);   // R2 unaligned erase
    // constrained random
    for (int i = 0; i < 40; i++) begin
      bit o = $urandom_range(0, 1);
      bit good = $urandom_range(0, 4) != 0;
      logic [7:0] b = good ? 8'($urandom_range(0, 31)) : 8'($urandom_range(0, 255));
      logic [15:0] a;
      if (good) a = o ? (16'h8000 | 16'($urandom_range(0, 16'h3FFF)))
                      : (16'h8000 | (16'($urandom_range(0, 3)) << 12));
      else      a = 16'($urandom_range(0, 16'hFFFF));
      run_op(o, b, a, 8'($urandom_range(0, 255)), $urandom_range(0, 6),
             $urandom_range(0, 3) == 0 ? $urandom_range(0, 6) : -1,
             16'($urandom_range(1, 12)), $urandom_range(0, 5) == 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule